// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles hardware flow control for one UART channel. On the transmit side it gates a valid/ready start request from the serializer. While automatic CTS handling is on, a new character may begin only when the synchronized CTS pin is active. A character the serializer has already launched is not affected, because the block only decides whether the next start is accepted.

On the receive side it drives the RTS pin from the receive FIFO fill level. RTS drops when the fill level reaches a halt threshold and returns when the level falls to a resume threshold. Between the two thresholds the previous decision holds. The thresholds come from two 4-bit fields counted in groups of four characters. When the halt field is zero, the FIFO trigger level is used instead. When automatic RTS is off, the pin follows a software request bit.

Back-pressure rule: `tx_req_valid` may be raised at any time, and a start takes place in exactly the cycles where both `tx_req_valid` and `tx_req_ready` are high; those cycles are marked by `tx_start`. Both RTS and CTS are active-low at the pins.

Top module: `afc_flow_ctrl`

## Requirements
- R1: During and directly after reset, `rts_n` is 1 (inactive) and the CTS synchronizer holds the inactive state, so `tx_req_ready` equals NOT `auto_cts_en`.
- R2: With `auto_cts_en` low, `tx_req_ready` is 1 whatever `cts_n` does.
- R3: With `auto_cts_en` high, `tx_req_ready` is 1 exactly when the `cts_n` value sampled two clock edges earlier was 0 (two-stage synchronizer).
- R4: `tx_start` is 1 exactly in cycles where `tx_req_valid` and `tx_req_ready` are both 1. Only the start is gated.
- R5: With `auto_rts_en` low, `rts_n` after each clock edge equals NOT the `sw_rts` value sampled at that edge.
- R6: With `auto_rts_en` high and `halt_field` nonzero, the halt threshold is `halt_field`*4 characters. A fill level at or above it makes `rts_n` 1 after the next edge.
- R7: With `auto_rts_en` high, a fill level at or below the resume threshold (`resume_field`*4 when `halt_field` is nonzero) makes `rts_n` 0 after the next edge. A level strictly between resume and halt keeps the previous `rts_n`. While automatic RTS is off, the hysteresis state rests in the "run" (RTS active) condition.
- R8: When `halt_field` is 0, the halt threshold is `trig_level` (or 1 if `trig_level` is 0), the resume threshold is one below it, and `resume_field` is ignored.
- R9: With `auto_rts_en` high, a fill level at or above FIFO_DEPTH (64) forces `rts_n` to 1 after the next edge, regardless of the thresholds.
- R10: With both enables high and `rts_n` looped to `cts_n`, a full receive FIFO makes `tx_req_ready` 0 within three edges, and it returns to 1 within three edges of the FIFO draining to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_cts_en | input | 1 | Enables gating of transmit starts by CTS |
| auto_rts_en | input | 1 | Enables RTS driven by FIFO fill level |
| sw_rts | input | 1 | Software RTS request (1 = active) when automatic RTS is off |
| cts_n | input | 1 | CTS pin, active-low, asynchronous |
| rx_level | input | 7 | Receive FIFO fill level in characters (0..64) |
| halt_field | input | 4 | Halt threshold in units of 4 characters, 0 = use trigger level |
| resume_field | input | 4 | Resume threshold in units of 4 characters |
| trig_level | input | 7 | Fallback trigger level in characters |
| tx_req_valid | input | 1 | Serializer requests to start a character |
| tx_req_ready | output | 1 | Start permitted |
| tx_start | output | 1 | Start accepted this cycle |
| rts_n | output | 1 | RTS pin, active-low, registered |

## Verification
The assertions assume that `rx_level` never exceeds the FIFO depth. They also assume the programmed resume threshold sits below the halt threshold, so the window between them is well defined. The check on CTS blocking assumes that `cts_n` is steady around the sampling edge. The stimulus changes every input on the falling clock edge, only pairs resume fields strictly below halt fields, and sweeps `rx_level` only within 0..64.

// File: rtl/afc_pkg.sv
package afc_pkg;

  // Hysteresis state of the receive-side decision.
  typedef enum logic {
    HYS_RUN  = 1'b0,  // RTS active, peer may send
    HYS_HOLD = 1'b1   // RTS inactive, peer must pause
  } hys_state_e;

endpackage

// File: rtl/afc_cts_gate.sv
module afc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_cts_en,
  input  logic tx_req_valid,
  output logic tx_req_ready,
  output logic tx_start
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cts_active;

  // Synchronizer chain; reset to the inactive (high) pin level.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= cts_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
      end
    end
  endgenerate

  assign cts_active   = ~sync_q[SYNC_STAGES-1];
  assign tx_req_ready = ~auto_cts_en | cts_active;
  assign tx_start     = tx_req_valid & tx_req_ready;

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      // R3: CTS inactive on the last two samples blocks every start
      a_r3_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && $past(cts_n) && $past(cts_n, 2)) |-> !tx_req_ready);
    end
  endgenerate

endmodule

// File: rtl/afc_thresh_sel.sv
module afc_thresh_sel #(
  parameter int LVL_W      = 7,
  parameter int FIELD_W    = 4,
  parameter int UNIT_SHIFT = 2
) (
  input  logic [FIELD_W-1:0] halt_field,
  input  logic [FIELD_W-1:0] resume_field,
  input  logic [LVL_W-1:0]   trig_level,
  output logic [LVL_W-1:0]   halt_lvl,
  output logic [LVL_W-1:0]   resume_lvl
);

  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic                use_fallback;
  logic [LVL_W-1:0]    prog_halt;
  logic [LVL_W-1:0]    prog_resume;
  logic [LVL_W-1:0]    fb_halt;

  assign use_fallback = (halt_field == '0);
  assign prog_halt    = LVL_W'(halt_field)   << UNIT_SHIFT;
  assign prog_resume  = LVL_W'(resume_field) << UNIT_SHIFT;
  assign fb_halt      = (trig_level == '0) ? ONE : trig_level;

  always_comb begin
    if (use_fallback) begin
      halt_lvl   = fb_halt;
      resume_lvl = fb_halt - ONE;
    end else begin
      halt_lvl   = prog_halt;
      resume_lvl = prog_resume;
    end
  end

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
  import afc_pkg::*;
#(
  parameter int LVL_W      = 7,
  parameter int FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             rts_n
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  hys_state_e st_q, st_d;
  logic       at_halt, at_resume;
  logic       rts_n_q;

  assign at_halt   = (rx_level >= FULL_LVL) || (rx_level >= halt_lvl);
  assign at_resume = (rx_level <= resume_lvl);

  always_comb begin
    st_d = st_q;
    if (!auto_rts_en)   st_d = HYS_RUN;
    else if (at_halt)   st_d = HYS_HOLD;
    else if (at_resume) st_d = HYS_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HYS_RUN;
      rts_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      rts_n_q <= auto_rts_en ? (st_d == HYS_HOLD) : ~sw_rts;
    end
  end

  assign rts_n = rts_n_q;

  // R9: a full FIFO always silences the peer
  a_r9_full_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= FULL_LVL) |=> rts_n);

  // R6: reaching the halt threshold deactivates RTS
  a_r6_halt_level: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= halt_lvl) |=> rts_n);

  // R5: software bit drives the pin while automatic RTS is off
  a_r5_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(sw_rts)));

  // R7: inside the hysteresis window the pin does not move
  a_r7_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(auto_rts_en) && auto_rts_en &&
     rx_level > resume_lvl && rx_level < halt_lvl && rx_level < FULL_LVL)
    |=> (rts_n == $past(rts_n)));

endmodule

// File: rtl/afc_flow_ctrl.sv
module afc_flow_ctrl #(
  parameter  int FIFO_DEPTH  = 64,
  parameter  int FIELD_W     = 4,
  parameter  int UNIT_SHIFT  = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_cts_en,
  input  logic               auto_rts_en,
  input  logic               sw_rts,
  input  logic               cts_n,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [FIELD_W-1:0] halt_field,
  input  logic [FIELD_W-1:0] resume_field,
  input  logic [LVL_W-1:0]   trig_level,
  input  logic               tx_req_valid,
  output logic               tx_req_ready,
  output logic               tx_start,
  output logic               rts_n
);

  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;

  afc_cts_gate #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cts_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .cts_n        (cts_n),
    .auto_cts_en  (auto_cts_en),
    .tx_req_valid (tx_req_valid),
    .tx_req_ready (tx_req_ready),
    .tx_start     (tx_start)
  );

  afc_thresh_sel #(
    .LVL_W      (LVL_W),
    .FIELD_W    (FIELD_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) u_thresh_sel (
    .halt_field   (halt_field),
    .resume_field (resume_field),
    .trig_level   (trig_level),
    .halt_lvl     (halt_lvl),
    .resume_lvl   (resume_lvl)
  );

  afc_rts_ctrl #(
    .LVL_W      (LVL_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_rts_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_rts_en (auto_rts_en),
    .sw_rts      (sw_rts),
    .rx_level    (rx_level),
    .halt_lvl    (halt_lvl),
    .resume_lvl  (resume_lvl),
    .rts_n       (rts_n)
  );

endmodule

// File: tb/afc_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module afc_flow_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_cts_en = 1'b0, auto_rts_en = 1'b0, sw_rts = 1'b0;
  logic       cts_bench = 1'b1, loop_en = 1'b0;
  logic       cts_n;
  logic [6:0] rx_level = '0, trig_level = '0;
  logic [3:0] halt_field = '0, resume_field = '0;
  logic       tx_req_valid = 1'b0;
  logic       tx_req_ready, tx_start, rts_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_on = 1, c1 = 1, c2 = 1, exp_rts_n = 1, auto_chk = 0;
  string tag_rts = "R5", tag_cts = "R2";

  always #2.5 clk = ~clk;
  assign cts_n = loop_en ? rts_n : cts_bench;

  afc_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .sw_rts(sw_rts), .cts_n(cts_n), .rx_level(rx_level), .halt_field(halt_field),
    .resume_field(resume_field), .trig_level(trig_level), .tx_req_valid(tx_req_valid),
    .tx_req_ready(tx_req_ready), .tx_start(tx_start), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endfunction

  // One clock edge; model follows the requirements, outputs checked 1 ns later.
  task automatic tick();
    int halt, res;
    bit exp_ready;
    @(posedge clk);
    if (!auto_rts_en) begin
      m_on = 1; exp_rts_n = !sw_rts;                       // R5, R7 rest state
    end else begin
      if (halt_field != 0) begin halt = halt_field * 4; res = resume_field * 4; end // R6
      else begin halt = (trig_level == 0) ? 1 : trig_level; res = halt - 1; end      // R8
      if (rx_level >= 64 || rx_level >= halt) m_on = 0;    // R9, R6
      else if (rx_level <= res) m_on = 1;                  // R7
      exp_rts_n = !m_on;
    end
    c2 = c1; c1 = cts_n;
    #1;
    if (auto_chk) begin
      exp_ready = !auto_cts_en || !c2;                     // R2, R3
      chk(rts_n == exp_rts_n, tag_rts, rts_n, exp_rts_n);
      chk(tx_req_ready == exp_ready, tag_cts, tx_req_ready, exp_ready);
      chk(tx_start == (tx_req_valid && exp_ready), "R4", tx_start, tx_req_valid && exp_ready);
    end
  endtask

  task automatic drive_lvl(input int lvl);
    @(negedge clk);
    rx_level = 7'(lvl);
    if (lvl >= 64) tag_rts = "R9";
    else if (halt_field == 0) tag_rts = "R8";
    else tag_rts = "R6 R7";
    tick();
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state with auto-CTS requested
    auto_cts_en = 1; cts_bench = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(rts_n == 1, "R1", rts_n, 1);
    chk(tx_req_ready == 0, "R1", tx_req_ready, 0);
    @(negedge clk); rst_n = 1; auto_cts_en = 0; cts_bench = 1;
    #1;
    chk(rts_n == 1, "R1", rts_n, 1);
    chk(tx_req_ready == 1, "R1", tx_req_ready, 1);
    auto_chk = 1;

    // R5: software RTS with automatic RTS off, levels varied
    tag_rts = "R5";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sw_rts = ((i * 7) % 5) < 2;
      rx_level = 7'((i * 13) % 65);
      tick();
    end

    // R6, R7, R9: programmed thresholds, ramp up and down
    auto_rts_en = 1;
    for (int hf = 1; hf < 16; hf++) begin
      for (int rf = 0; rf < hf; rf++) begin
        @(negedge clk); halt_field = 4'(hf); resume_field = 4'(rf);
        tick();
        for (int l = 0; l <= 64; l++) drive_lvl(l);
        for (int l = 64; l >= 0; l--) drive_lvl(l);
      end
    end

    // R8, R9: fallback to trigger level, resume field ignored
    for (int tg = 0; tg <= 80; tg++) begin
      @(negedge clk); halt_field = 0; resume_field = 4'(tg % 16); trig_level = 7'(tg);
      tick();
      for (int l = 0; l <= 64; l++) drive_lvl(l);
      for (int l = 64; l >= 0; l--) drive_lvl(l);
    end

    // R7: disabling resets hysteresis to run
    @(negedge clk); auto_rts_en = 0; sw_rts = 0; tag_rts = "R5"; tick();
    @(negedge clk); auto_rts_en = 1; halt_field = 8; resume_field = 2; rx_level = 20;
    tag_rts = "R7"; tick(); tick();

    // R2, R3, R4: CTS patterns with and without auto-CTS
    for (int a = 0; a < 2; a++) begin
      tag_cts = (a == 0) ? "R2" : "R3";
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        auto_cts_en = a[0];
        cts_bench = ((i >> (i % 3)) & 1) != 0;
        tx_req_valid = (i % 3) != 1;
        tick();
      end
    end

    // R10: loopback of RTS to CTS
    auto_chk = 0;
    @(negedge clk);
    auto_cts_en = 1; auto_rts_en = 1; halt_field = 0; trig_level = 100;
    rx_level = 0; tx_req_valid = 1; loop_en = 1;
    repeat (4) tick();
    chk(tx_req_ready == 1, "R10", tx_req_ready, 1);
    @(negedge clk); rx_level = 64;
    repeat (3) tick();
    chk(tx_req_ready == 0, "R10", tx_req_ready, 0);
    chk(tx_start == 0, "R10", tx_start, 0);
    @(negedge clk); rx_level = 0;
    repeat (3) tick();
    chk(tx_req_ready == 1, "R10", tx_req_ready, 1);
    chk(tx_start == 1, "R10", tx_start, 1);

    summary();
    $finish;
  end

endmodule